// File: doc/BRIEF.md
# Serial Register Access Port

This block is a clocked serial slave that lets an external host read and write an 8-bit-addressed register space. Each transaction is framed by an active-low chip select. The first byte shifted in names the register. Every later byte in the same frame is either write data or a slot in which register contents are shifted back out. A direction input picks the mode of the frame. Bits travel least significant first. The host's shift clock, chip select, serial input and direction input are brought into the system clock domain through synchronizers, and all edge detection happens on that clock.

After the address byte, the port raises a wait output for a short fixed window while it performs the internal access. During that window a read fetches the first register value. Successive data bytes in a frame go to successive addresses, and the address wraps from 0xFF to 0x00. The register storage sits outside the block. The port drives an address, a one-cycle write strobe with data, and a one-cycle read strobe, and it expects the read value one system clock after that strobe. The host's shift clock must run at no more than one sixteenth of the system clock, with each half period at least eight system clocks.

Top module: `ser_regport`

## Requirements
- R1: The serial input is sampled on rising shift clock edges. The first complete byte of a frame is the register address, with its first bit as address bit 0.
- R2: In a write frame (direction input low at the end of the address byte), each completed data byte produces exactly one `reg_wr` pulse one system clock long, carrying that byte and the current address.
- R3: After each data byte the address advances by one and wraps from 0xFF to 0x00. This applies to both reads and writes.
- R4: In a read frame (direction input high), `sdo` is 0 for all eight address-byte bit slots. In each data byte, bit 0 of the register value is on `sdo` before the byte's first rising shift clock edge. Each later bit appears after the falling shift clock edge that ends the previous bit.
- R5: `sdo_oe` is 1 only while chip select is low and the direction input is high. Otherwise it is 0, and the host treats `sdo` as released.
- R6: Each completed address byte, in either direction, raises `wait_o` for exactly 3 system clocks. Data bytes never raise it.
- R7: Raising chip select in the middle of a byte discards the partial byte. No write is issued for it, and the next frame starts again with an address byte.
- R8: A read frame issues one `reg_rd` pulse one system clock long at the end of the address byte and one after each data byte. It issues no `reg_wr`.
- R9: In the cycle after synchronous reset, `wait_o`, `reg_wr`, `reg_rd`, `sdo` and `sdo_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Host shift clock |
| sdi | input | 1 | Serial data from the host, LSB first |
| rw_sel | input | 1 | Frame direction: 1 read, 0 write |
| sdo | output | 1 | Serial data to the host, LSB first |
| sdo_oe | output | 1 | High while `sdo` is actively driven |
| wait_o | output | 1 | Host must pause while high |
| reg_addr | output | 8 | Register address of the current access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data presented with `reg_wr` |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid one cycle after `reg_rd` |

## Verification
The bench reads back address 0x01 and address 0x80 with distinct contents. A design that shifted bits in MSB first would return the two values swapped. A burst that starts at 0xFF must land its second byte at 0x00, and a missing wrap would write 0x100 truncated to the wrong place or stay put. Frames cut off in the middle of an address byte or a data byte must leave no write behind. A leaked partial byte shows up as an unexpected entry at the write monitor, or as a changed value on readback. The bench also measures every wait pulse, so a pulse that is too long or that follows data bytes is caught. It checks that the dummy address-phase bits read as 0, which catches a design that shifts stale data out early.

// File: rtl/ser_regport_pkg.sv
package ser_regport_pkg;
  typedef enum logic [1:0] {
    BK_ADDR  = 2'd0,
    BK_WRITE = 2'd1,
    BK_READ  = 2'd2
  } byte_kind_e;
endpackage

// File: rtl/ser_regport_sync.sv
module ser_regport_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[i]}};
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/ser_regport_framer.sv
module ser_regport_framer
  import ser_regport_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              rise,
  input  logic              sdi_s,
  input  logic              rw_s,
  output logic [BYTE_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd,
  output logic              wait_o,
  output logic              mid_byte,
  output logic              load_tx
);
  localparam int CW       = $clog2(BYTE_W);
  localparam int WAIT_CYC = RD_LAT + 2;
  localparam int WCW      = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] addr_q;
  logic              first_q;
  logic              mode_rd;
  logic [WCW-1:0]    wait_cnt;
  logic [RD_LAT-1:0] rd_pipe;
  logic [BYTE_W-1:0] byte_full;
  byte_kind_e        kind;

  assign byte_full = {sdi_s, shreg[BYTE_W-1:1]};
  assign kind      = first_q ? BK_ADDR : (mode_rd ? BK_READ : BK_WRITE);
  assign mid_byte  = (bit_cnt != '0);
  assign load_tx   = rd_pipe[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      addr_q    <= '0;
      first_q   <= 1'b1;
      mode_rd   <= 1'b0;
      wait_cnt  <= '0;
      wait_o    <= 1'b0;
      rd_pipe   <= '0;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      rd_pipe <= (rd_pipe << 1) | RD_LAT'(reg_rd);
      if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
        wait_o   <= (wait_cnt > WCW'(1));
      end
      if (idle) begin
        bit_cnt  <= '0;
        shreg    <= '0;
        first_q  <= 1'b1;
        mode_rd  <= 1'b0;
        wait_cnt <= '0;
        wait_o   <= 1'b0;
      end else if (rise) begin
        shreg   <= byte_full;
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          case (kind)
            BK_ADDR: begin
              first_q  <= 1'b0;
              addr_q   <= byte_full;
              mode_rd  <= rw_s;
              wait_cnt <= WCW'(WAIT_CYC);
              wait_o   <= 1'b1;
              if (rw_s) begin
                reg_rd   <= 1'b1;
                reg_addr <= byte_full;
              end
            end
            BK_READ: begin
              addr_q   <= addr_q + 1'b1;
              reg_rd   <= 1'b1;
              reg_addr <= addr_q + 1'b1;
            end
            default: begin
              reg_wr    <= 1'b1;
              reg_addr  <= addr_q;
              reg_wdata <= byte_full;
              addr_q    <= addr_q + 1'b1;
            end
          endcase
        end
      end
    end
  end

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_o) |=> wait_o);
  assert_single_rd_R8: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);
  assert_idle_no_wr_R7: assert property (@(posedge clk) disable iff (rst)
    idle |=> !reg_wr);
endmodule

// File: rtl/ser_regport_txshift.sv
module ser_regport_txshift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              fall,
  input  logic              mid_byte,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              sdo
);
  logic [BYTE_W-1:0] tx;

  always_ff @(posedge clk) begin
    if (rst || idle)          tx <= '0;
    else if (load)            tx <= load_data;
    else if (fall && mid_byte) tx <= {1'b0, tx[BYTE_W-1:1]};
  end

  assign sdo = tx[0];
endmodule

// File: rtl/ser_regport.sv
module ser_regport #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RD_LAT      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              rw_sel,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wait_o,
  output logic [BYTE_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [3:0] s;
  logic       sclk_d;
  logic       rise, fall, mid_byte, load_tx;
  logic       cs_s, rw_s, sdi_s, sclk_s;

  ser_regport_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, rw_sel, sdi, sclk}),
    .q   (s)
  );
  assign {cs_s, rw_s, sdi_s, sclk_s} = s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sdo_oe <= ~cs_s & rw_s;
    end
  end
  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  ser_regport_framer #(.BYTE_W(BYTE_W), .RD_LAT(RD_LAT)) i_framer (
    .clk       (clk),
    .rst       (rst),
    .idle      (cs_s),
    .rise      (rise),
    .sdi_s     (sdi_s),
    .rw_s      (rw_s),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .wait_o    (wait_o),
    .mid_byte  (mid_byte),
    .load_tx   (load_tx)
  );

  ser_regport_txshift #(.BYTE_W(BYTE_W)) i_tx (
    .clk       (clk),
    .rst       (rst),
    .idle      (cs_s),
    .fall      (fall),
    .mid_byte  (mid_byte),
    .load      (load_tx),
    .load_data (reg_rdata),
    .sdo       (sdo)
  );

  assert_oe_idle_R5: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe);
  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wait_o && !reg_wr && !reg_rd && !sdo_oe));
endmodule

// File: tb/test_ser_regport.sv
module test_ser_regport;
  localparam int H = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, rw_sel = 1'b0;
  logic sdo, sdo_oe, wait_o, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  int vectors = 0, errors = 0;
  int wait_pulses = 0, exp_wait_pulses = 0, wait_run = 0;
  logic [15:0] exp_q[$];
  logic [7:0] shadow [256];
  logic [7:0] ram [256];

  always #10 clk = ~clk;

  ser_regport i_ser_regport (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .rw_sel(rw_sel),
    .sdo(sdo), .sdo_oe(sdo_oe), .wait_o(wait_o), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]    = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
  end

  always @(posedge clk) begin
    if (reg_wr) ram[reg_addr] <= reg_wdata;
    if (reg_rd) reg_rdata <= ram[reg_addr];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: writes and wait pulse lengths
  always @(negedge clk) begin
    if (!rst && reg_wr) begin
      if (exp_q.size() == 0) check(0, "R2/R7 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({reg_addr, reg_wdata} == e, "R2/R3 write addr,data", {reg_addr, reg_wdata}, e);
      end
    end
    if (!rst && reg_wr && rw_sel) check(0, "R8 write in read frame", 1, 0);
    if (wait_o) wait_run++;
    else if (wait_run != 0) begin
      check(wait_run == 3, "R6 wait length", wait_run, 3);
      wait_pulses++;
      wait_run = 0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      sdi = b[i];
      sclk = 1'b0;
      tick(H);
      got[i] = sdo;
      sclk = 1'b1;
      tick(H);
      sclk = 1'b0;
    end
  endtask

  task automatic open_frame(input logic rd);
    rw_sel = rd;
    tick(3);
    cs_n = 1'b0;
    tick(6);
  endtask

  task automatic close_frame();
    tick(H);
    cs_n = 1'b1;
    tick(10);
    check(sdo_oe == 1'b0, "R5 oe after deselect", sdo_oe, 0);
  endtask

  task automatic write_frame(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1, input int n);
    logic [7:0] got;
    logic [7:0] aa;
    open_frame(1'b0);
    xfer_bits(a, 8, got);
    exp_wait_pulses++;
    tick(H);
    check(sdo_oe == 1'b0, "R5 oe in write frame", sdo_oe, 0);
    aa = a;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = (k == 0) ? d0 : d1;
      exp_q.push_back({aa, d});
      shadow[aa] = d;
      xfer_bits(d, 8, got);
      tick(H);
      aa = aa + 8'd1;
    end
    close_frame();
    check(exp_q.size() == 0, "R2 write count", exp_q.size(), 0);
  endtask

  task automatic read_frame(input logic [7:0] a, input int n, input string tag);
    logic [7:0] got;
    logic [7:0] aa;
    open_frame(1'b1);
    xfer_bits(a, 8, got);
    exp_wait_pulses++;
    check(got == 8'h00, "R4 dummy address bits", got, 0);
    tick(H);
    check(sdo_oe == 1'b1, "R5 oe in read frame", sdo_oe, 1);
    aa = a;
    for (int k = 0; k < n; k++) begin
      xfer_bits(8'h00, 8, got);
      check(got == shadow[aa], tag, got, shadow[aa]);
      tick(H);
      aa = aa + 8'd1;
    end
    close_frame();
  endtask

  initial begin
    logic [7:0] junk;
    tick(4);
    rst = 1'b0;
    tick(1);
    check(sdo_oe == 0 && wait_o == 0, "R9 reset oe/wait", {sdo_oe, wait_o}, 0);
    check(reg_wr == 0 && reg_rd == 0 && sdo == 0, "R9 reset strobes", {reg_wr, reg_rd, sdo}, 0);

    // R1: asymmetric addresses distinguish bit order
    read_frame(8'h01, 1, "R1 read addr 01");
    read_frame(8'h80, 1, "R1 read addr 80");

    // R2: single and double byte writes
    write_frame(8'h3C, 8'hA5, 8'h00, 1);
    write_frame(8'h40, 8'h12, 8'hEF, 2);
    read_frame(8'h3C, 1, "R2 readback 3C");
    read_frame(8'h40, 2, "R3 R4 burst read 40..41");

    // R3: wrap at top of address space
    write_frame(8'hFF, 8'h77, 8'h99, 2);
    read_frame(8'hFF, 2, "R3 wrap read FF..00");

    // R7: partial address byte then deselect
    open_frame(1'b0);
    xfer_bits(8'h55, 5, junk);
    cs_n = 1'b1;
    tick(12);
    write_frame(8'h20, 8'hC3, 8'h00, 1);
    read_frame(8'h20, 1, "R7 frame after partial address");

    // R7: partial data byte after one full byte
    open_frame(1'b0);
    xfer_bits(8'h60, 8, junk);
    exp_wait_pulses++;
    tick(H);
    exp_q.push_back({8'h60, 8'h3E});
    shadow[8'h60] = 8'h3E;
    xfer_bits(8'h3E, 8, junk);
    tick(H);
    xfer_bits(8'hFF, 3, junk);
    close_frame();
    read_frame(8'h61, 1, "R7 partial data byte discarded");
    read_frame(8'h60, 1, "R7 full byte before partial kept");

    // R8: read frame must not write; data reads back unchanged
    read_frame(8'h41, 1, "R8 read has no side effect");

    tick(20);
    check(exp_q.size() == 0, "R2 pending writes", exp_q.size(), 0);
    check(wait_pulses == exp_wait_pulses, "R6 wait pulse count", wait_pulses, exp_wait_pulses);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    vectors++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule